// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the serial slave side of a small byte-wide flash-style memory. It watches chip select, serial clock and serial data and takes bits in most-significant first. The first byte after chip select falls is the command. Depending on that command, the block gathers a 24-bit address, hands later bytes to the core, or streams bytes from the core out on the serial output. The memory array, its timing and any write-protection policy are outside the block. The core sees one-cycle strobes, an address bus and a received byte bus. It answers output requests with a byte on `txData`.

All logic runs on a fast system clock `clk`. The serial pins are treated as synchronous inputs, and each serial clock level must last at least three `clk` cycles. Serial clock edges are found by comparing `spiSck` with its value on the previous cycle. Data is sampled on rising serial clock edges and shifted out on falling edges. Because of this, serial clock idle low (mode 0) and idle high (mode 3) both work without any configuration.

Top module: `spiFlashFrontEnd`

## Requirements
- R1: The block works in serial clock mode 0 (idle low) and in mode 3 (idle high) with no setting. `spiSi` is sampled on rising `spiSck`, most significant bit first. `spiSo` changes only after falling `spiSck`.
- R2: The first byte of each selected transfer is the command. One `clk` cycle after the cycle that sees its eighth rising serial edge, exactly one bit of `cmdStrobe` pulses for one cycle. The bits are: bit0 for 0000_0110 (write enable), bit1 for 0000_0100 (write disable), bit2 for 0000_0101 (status read), bit3 for 0000_0001 (status write), bit4 for 0000_0011 (array read), bit5 for 0000_0010 (array program), bit6 for 0101_0010 (sector erase), bit7 for 0110_0010 (full erase), and bit8 for 0001_0101 (identity read).
- R3: Bit 3 of the command byte has no effect on decoding.
- R4: `cmdWrite` pulses together with the strobe only for status write, array program, sector erase and full erase.
- R5: For array read, array program and sector erase, the next three bytes form `addr`, first byte in bits 23:16. `addrValid` pulses one cycle after the third address byte completes, and `addr` holds the full value at that time.
- R6: For status write, and for array program after its address, each further byte appears on `rxData` with a one-cycle `rxValid` pulse one cycle after the byte completes.
- R7: For status read, identity read, and array read after its address, `txReq` pulses one cycle after the byte that ends the header and one cycle after every later byte. `txData` is taken on the clock edge that ends the `txReq` cycle. That byte is shifted out MSB first, starting at the next falling serial edge. `spiSoEn` is high during this streaming phase, which lasts until chip select rises.
- R8: After write enable, write disable or full erase, and after the address of a sector erase, further bytes cause no strobe, no `rxValid`, no `txReq`, and `spiSoEn` stays low.
- R9: An undefined command locks the transfer: no strobes or pulses occur and `spiSoEn` stays low until chip select rises. The next transfer decodes normally.
- R10: While `spiCsN` is high, `spiSi` is ignored and no pulse occurs. `spiSoEn` is low from one cycle after `spiCsN` rises. A partly received byte is dropped when chip select rises.
- R11: After reset, all strobes and pulses are low and `spiSoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Chip select, active low |
| spiSck | input | 1 | Serial clock |
| spiSi | input | 1 | Serial data in |
| spiSo | output | 1 | Serial data out |
| spiSoEn | output | 1 | Output enable for spiSo |
| cmdStrobe | output | 9 | One-hot command pulse |
| cmdWrite | output | 1 | Pulse marking a write-class command |
| addrValid | output | 1 | Address complete pulse |
| addr | output | 24 | Received address |
| rxValid | output | 1 | Received data byte pulse |
| rxData | output | 8 | Received data byte |
| txReq | output | 1 | Request for the next outbound byte |
| txData | input | 8 | Outbound byte from the core |

## Verification
`cmdStrobe`, `addrValid`, `rxValid` and `txReq` must all appear exactly one `clk` cycle after the cycle in which the eighth rising serial edge of their byte is seen. The bench records the clock index at which it raises `spiSck`, and a monitor flags any pulse that shows up at a different index. The bench supplies `txData` at the falling `clk` edge where it first sees `txReq`, which meets the load edge at the end of that cycle. Output bits are read just before the next rising serial edge, when the value driven after the preceding falling edge has had half a serial period to settle.

// File: rtl/spiFePkg.sv
package spiFePkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_CMDS = 9;

  typedef enum logic [3:0] {
    CMD_WR_ENABLE    = 4'd0,
    CMD_WR_DISABLE   = 4'd1,
    CMD_STATUS_RD    = 4'd2,
    CMD_STATUS_WR    = 4'd3,
    CMD_ARRAY_RD     = 4'd4,
    CMD_ARRAY_PROG   = 4'd5,
    CMD_SECTOR_ERASE = 4'd6,
    CMD_FULL_ERASE   = 4'd7,
    CMD_IDENT_RD     = 4'd8,
    CMD_NONE         = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_ADDR, PH_DATA_IN, PH_DATA_OUT, PH_IGNORE, PH_LOCKED
  } phase_e;

  // datapath -> control
  typedef struct packed {
    logic              byteDone;
    logic [BYTE_W-1:0] rxByte;
  } dpStat_t;

  // control -> datapath
  typedef struct packed {
    logic addrShift;
    logic txLoad;
    logic outActive;
  } ctlStrobe_t;

  // bit 3 is dropped before the compare
  function automatic cmd_e decodeOp(input logic [BYTE_W-1:0] op);
    case ({op[7:4], op[2:0]})
      7'b0000_110: return CMD_WR_ENABLE;
      7'b0000_100: return CMD_WR_DISABLE;
      7'b0000_101: return CMD_STATUS_RD;
      7'b0000_001: return CMD_STATUS_WR;
      7'b0000_011: return CMD_ARRAY_RD;
      7'b0000_010: return CMD_ARRAY_PROG;
      7'b0101_010: return CMD_SECTOR_ERASE;
      7'b0110_010: return CMD_FULL_ERASE;
      7'b0001_101: return CMD_IDENT_RD;
      default:     return CMD_NONE;
    endcase
  endfunction

  function automatic logic isWriteCmd(input cmd_e c);
    return (c == CMD_STATUS_WR) || (c == CMD_ARRAY_PROG) ||
           (c == CMD_SECTOR_ERASE) || (c == CMD_FULL_ERASE);
  endfunction
endpackage

// File: rtl/spiFeDatapath.sv
module spiFeDatapath
  import spiFePkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  ctlStrobe_t        ctl,
  input  logic [BYTE_W-1:0] txData,
  output dpStat_t           stat,
  output logic              so,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] rxData
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              sckPrev;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] shiftIn;
  logic [BYTE_W-1:0] shiftOut;
  logic              soReg;
  logic [ADDR_W-1:0] addrReg;
  logic [BYTE_W-1:0] rxReg;
  logic              selected, sckRise, sckFall;

  assign selected = !csN;
  assign sckRise  = selected &&  sck && !sckPrev;
  assign sckFall  = selected && !sck &&  sckPrev;

  assign stat.byteDone = sckRise && (bitCnt == BIT_W'(BYTE_W - 1));
  assign stat.rxByte   = {shiftIn, si};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      shiftIn  <= '0;
      shiftOut <= '0;
      soReg    <= 1'b0;
    end else begin
      sckPrev <= sck;
      if (!selected) begin
        bitCnt  <= '0;            // partial byte dropped
        shiftIn <= '0;
        soReg   <= 1'b0;
      end else begin
        if (sckRise) begin
          bitCnt  <= bitCnt + 1'b1;
          shiftIn <= {shiftIn[BYTE_W-3:0], si};
        end
        if (ctl.txLoad) begin
          shiftOut <= txData;
        end else if (sckFall && ctl.outActive) begin
          soReg    <= shiftOut[BYTE_W-1];
          shiftOut <= {shiftOut[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      rxReg   <= '0;
    end else begin
      if (stat.byteDone) rxReg <= stat.rxByte;
      if (ctl.addrShift) addrReg <= {addrReg[ADDR_W-BYTE_W-1:0], stat.rxByte};
    end
  end

  assign so     = soReg;
  assign addr   = addrReg;
  assign rxData = rxReg;
endmodule

// File: rtl/spiFeControl.sv
module spiFeControl
  import spiFePkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  dpStat_t             stat,
  output ctlStrobe_t          ctl,
  output logic [NUM_CMDS-1:0] cmdStrobe,
  output logic                cmdWrite,
  output logic                addrValid,
  output logic                rxValid,
  output logic                txReq
);
  phase_e              phase;
  cmd_e                cmd;
  cmd_e                decoded;
  logic [CNT_W-1:0]    addrCnt;
  logic [NUM_CMDS-1:0] strobeReg;
  logic                writeReg, addrValidReg, rxValidReg, txReqReg;

  assign decoded = decodeOp(stat.rxByte);

  assign ctl.addrShift = stat.byteDone && (phase == PH_ADDR);
  assign ctl.txLoad    = txReqReg;
  assign ctl.outActive = (phase == PH_DATA_OUT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_OPCODE;
      cmd          <= CMD_NONE;
      addrCnt      <= '0;
      strobeReg    <= '0;
      writeReg     <= 1'b0;
      addrValidReg <= 1'b0;
      rxValidReg   <= 1'b0;
      txReqReg     <= 1'b0;
    end else begin
      strobeReg    <= '0;
      writeReg     <= 1'b0;
      addrValidReg <= 1'b0;
      rxValidReg   <= 1'b0;
      txReqReg     <= 1'b0;
      if (csN) begin
        phase   <= PH_OPCODE;
        addrCnt <= '0;
      end else if (stat.byteDone) begin
        case (phase)
          PH_OPCODE: begin
            if (decoded == CMD_NONE) begin
              phase <= PH_LOCKED;
            end else begin
              cmd       <= decoded;
              strobeReg <= NUM_CMDS'(1) << decoded;
              writeReg  <= isWriteCmd(decoded);
              case (decoded)
                CMD_ARRAY_RD, CMD_ARRAY_PROG, CMD_SECTOR_ERASE: begin
                  phase   <= PH_ADDR;
                  addrCnt <= '0;
                end
                CMD_STATUS_WR: phase <= PH_DATA_IN;
                CMD_STATUS_RD, CMD_IDENT_RD: begin
                  phase    <= PH_DATA_OUT;
                  txReqReg <= 1'b1;
                end
                default: phase <= PH_IGNORE;
              endcase
            end
          end
          PH_ADDR: begin
            if (addrCnt == CNT_W'(ADDR_BYTES - 1)) begin
              addrValidReg <= 1'b1;
              case (cmd)
                CMD_ARRAY_RD: begin
                  phase    <= PH_DATA_OUT;
                  txReqReg <= 1'b1;
                end
                CMD_ARRAY_PROG: phase <= PH_DATA_IN;
                default:        phase <= PH_IGNORE;
              endcase
            end else begin
              addrCnt <= addrCnt + 1'b1;
            end
          end
          PH_DATA_IN:  rxValidReg <= 1'b1;
          PH_DATA_OUT: txReqReg   <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign cmdStrobe = strobeReg;
  assign cmdWrite  = writeReg;
  assign addrValid = addrValidReg;
  assign rxValid   = rxValidReg;
  assign txReq     = txReqReg;
endmodule

// File: rtl/spiFlashFrontEnd.sv
module spiFlashFrontEnd
  import spiFePkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spiCsN,
  input  logic                spiSck,
  input  logic                spiSi,
  output logic                spiSo,
  output logic                spiSoEn,
  output logic [NUM_CMDS-1:0] cmdStrobe,
  output logic                cmdWrite,
  output logic                addrValid,
  output logic [ADDR_W-1:0]   addr,
  output logic                rxValid,
  output logic [BYTE_W-1:0]   rxData,
  output logic                txReq,
  input  logic [BYTE_W-1:0]   txData
);
  dpStat_t    stat;
  ctlStrobe_t ctl;

  spiFeDatapath #(.ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .csN(spiCsN), .sck(spiSck), .si(spiSi),
    .ctl(ctl), .txData(txData), .stat(stat), .so(spiSo),
    .addr(addr), .rxData(rxData)
  );

  spiFeControl #(.ADDR_BYTES(ADDR_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .csN(spiCsN), .stat(stat), .ctl(ctl),
    .cmdStrobe(cmdStrobe), .cmdWrite(cmdWrite), .addrValid(addrValid),
    .rxValid(rxValid), .txReq(txReq)
  );

  assign spiSoEn = ctl.outActive;
endmodule

// File: rtl/spiFlashFrontEndChk.sv
module spiFlashFrontEndChk (
  input logic       clk,
  input logic       rstN,
  input logic       spiCsN,
  input logic       spiSoEn,
  input logic [8:0] cmdStrobe,
  input logic       cmdWrite,
  input logic       addrValid,
  input logic       rxValid,
  input logic       txReq
);
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStrobe)); // R2

  AST_WRITE_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |-> ((cmdStrobe & 9'h0E8) != 9'h000)); // R4

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && $past(spiCsN)) |-> (!spiSoEn && cmdStrobe == 9'h000 && !rxValid && !txReq && !addrValid)); // R10

  AST_HEADER_APART: assert property (@(posedge clk) disable iff (!rstN)
    (|cmdStrobe) |-> (!addrValid && !rxValid)); // R5

  AST_IN_OUT_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && txReq)); // R6

  AST_OUT_STARTS_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSoEn) |-> txReq); // R7
endmodule

bind spiFlashFrontEnd spiFlashFrontEndChk u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSoEn(spiSoEn),
  .cmdStrobe(cmdStrobe), .cmdWrite(cmdWrite), .addrValid(addrValid),
  .rxValid(rxValid), .txReq(txReq)
);

// File: tb/spiFlashFrontEnd_tb.sv
module spiFlashFrontEnd_tb;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0, spiCsN = 1'b1, spiSck = 1'b0, spiSi = 1'b0;
  logic [7:0] txData = 8'h00;
  logic spiSo, spiSoEn, cmdWrite, addrValid, rxValid, txReq;
  logic [8:0] cmdStrobe;
  logic [23:0] addr;
  logic [7:0] rxData;

  spiFlashFrontEnd u_dut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiSi(spiSi),
    .spiSo(spiSo), .spiSoEn(spiSoEn), .cmdStrobe(cmdStrobe), .cmdWrite(cmdWrite),
    .addrValid(addrValid), .addr(addr), .rxValid(rxValid), .rxData(rxData),
    .txReq(txReq), .txData(txData)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCmp = 0, nBad = 0;
  bit done = 0;
  logic [7:0] txBuf [16];
  logic [7:0] soBuf [16];
  logic [7:0] rxSeen [16];
  int strobeCnt, writeCnt, addrCnt, rxCnt, reqCnt, soEnCnt, lateCnt, deselCnt;
  int lastRise = -10;
  logic [8:0] lastStrobe;
  logic [23:0] lastAddr;
  logic csPrev = 1'b1;

  task automatic chk(input string tag, input longint act, input longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expKind(input logic [7:0] op);
    case ({op[7:4], op[2:0]})
      7'b0000_110: return 0;
      7'b0000_100: return 1;
      7'b0000_101: return 2;
      7'b0000_001: return 3;
      7'b0000_011: return 4;
      7'b0000_010: return 5;
      7'b0101_010: return 6;
      7'b0110_010: return 7;
      7'b0001_101: return 8;
      default:     return -1;
    endcase
  endfunction

  function automatic logic [7:0] resp(input int j);
    return 8'(32'hC3 ^ (j * 37));
  endfunction

  // monitor and outbound byte responder
  initial forever begin
    @(negedge clk);
    if (cmdStrobe != 9'h000) begin
      strobeCnt++; lastStrobe = cmdStrobe;
      if (cyc != lastRise + 1) lateCnt++;
    end
    if (cmdWrite) writeCnt++;
    if (addrValid) begin
      addrCnt++; lastAddr = addr;
      if (cyc != lastRise + 1) lateCnt++;
    end
    if (rxValid) begin
      if (rxCnt < 16) rxSeen[rxCnt] = rxData;
      rxCnt++;
      if (cyc != lastRise + 1) lateCnt++;
    end
    if (txReq) begin
      txData = resp(reqCnt);
      reqCnt++;
      if (cyc != lastRise + 1) lateCnt++;
    end
    if (spiSoEn) soEnCnt++;
    if (spiCsN && csPrev && (spiSoEn || cmdStrobe != 9'h000 || rxValid || txReq || addrValid))
      deselCnt++;
    csPrev = spiCsN;
  end

  task automatic runTxn(input int mode, input int n, input int lastBits);
    spiSck = (mode == 3);
    repeat (3) @(negedge clk);
    strobeCnt = 0; writeCnt = 0; addrCnt = 0; rxCnt = 0; reqCnt = 0;
    soEnCnt = 0; lateCnt = 0; deselCnt = 0; lastStrobe = '0; lastAddr = '0;
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= ((b == n - 1) ? 8 - lastBits : 0); i--) begin
        spiSck = 1'b0; spiSi = txBuf[b][i];
        repeat (HALF) @(negedge clk);
        soBuf[b][i] = spiSo;
        spiSck = 1'b1; lastRise = cyc;
        repeat (HALF) @(negedge clk);
      end
    end
    if (mode == 0) spiSck = 1'b0;
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic verifyTxn(input int n);
    int k, hdr, body;
    k = expKind(txBuf[0]);
    chk("R2 pulse timing", lateCnt, 0);
    chk("R10 quiet while deselected", deselCnt, 0);
    if (k < 0) begin
      chk("R9 no strobe", strobeCnt, 0);
      chk("R9 no address", addrCnt, 0);
      chk("R9 no rx", rxCnt, 0);
      chk("R9 no tx request", reqCnt, 0);
      chk("R9 output disabled", soEnCnt, 0);
      return;
    end
    chk("R2 R3 strobe count", strobeCnt, 1);
    chk("R2 R3 strobe bit", lastStrobe, 9'(1) << k);
    chk("R4 write class", writeCnt, (k == 3 || k == 5 || k == 6 || k == 7) ? 1 : 0);
    hdr = (k == 4 || k == 5 || k == 6) ? 4 : 1;
    body = (n > hdr) ? n - hdr : 0;
    if (hdr == 4) begin
      chk("R5 address pulse", addrCnt, (n >= 4) ? 1 : 0);
      if (n >= 4) chk("R5 address value", lastAddr, {txBuf[1], txBuf[2], txBuf[3]});
    end
    if (k == 3 || k == 5) begin
      chk("R6 rx count", rxCnt, body);
      for (int j = 0; j < body; j++) chk("R6 rx byte", rxSeen[j], txBuf[hdr + j]);
      chk("R6 no tx request", reqCnt, 0);
      chk("R6 output disabled", soEnCnt, 0);
    end else if (k == 2 || k == 4 || k == 8) begin
      chk("R7 tx request count", reqCnt, (n >= hdr) ? body + 1 : 0);
      chk("R7 no rx", rxCnt, 0);
      if (n >= hdr) chk("R7 output enabled", (soEnCnt > 0) ? 1 : 0, 1);
      for (int j = 0; j < body; j++) chk("R1 R7 serial out byte", soBuf[hdr + j], resp(j));
    end else begin
      chk("R8 no rx", rxCnt, 0);
      chk("R8 no tx request", reqCnt, 0);
      chk("R8 output disabled", soEnCnt, 0);
    end
  endtask

  task automatic directed(input int mode, input int n, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    txBuf[0] = b0; txBuf[1] = b1; txBuf[2] = b2; txBuf[3] = b3;
    for (int i = 4; i < 16; i++) txBuf[i] = 8'(32'h5A + i * 17);
    runTxn(mode, n, 8);
    verifyTxn(n);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=%0d expected=less", cyc);
    finishRun();
  end

  initial begin
    logic [7:0] validOps [9];
    validOps = '{8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h02, 8'h52, 8'h62, 8'h15};
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    // R11: outputs during and just after reset
    chk("R11 strobe in reset", cmdStrobe, 0);
    chk("R11 output enable in reset", spiSoEn, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 strobe after reset", cmdStrobe, 0);
    chk("R11 pulses after reset", {addrValid, rxValid, txReq, cmdWrite}, 0);
    chk("R11 output enable after reset", spiSoEn, 0);

    directed(0, 3, 8'h05, 8'h00, 8'h00, 8'h00);   // status read, mode 0
    directed(3, 7, 8'h03, 8'h12, 8'h34, 8'h56);   // array read, mode 3
    directed(0, 6, 8'h0A, 8'hAB, 8'hCD, 8'hEF);   // array program, bit 3 set (R3)
    directed(3, 2, 8'h01, 8'h9C, 8'h00, 8'h00);   // status write
    directed(0, 5, 8'h5A, 8'h01, 8'h02, 8'h03);   // sector erase, bit 3 set
    directed(3, 3, 8'h62, 8'h11, 8'h22, 8'h00);   // full erase, extra bytes
    directed(0, 1, 8'h06, 8'h00, 8'h00, 8'h00);   // write enable
    directed(3, 2, 8'h0C, 8'hFF, 8'h00, 8'h00);   // write disable, bit 3 set
    directed(0, 3, 8'h1D, 8'h00, 8'h00, 8'h00);   // identity read, bit 3 set
    directed(0, 4, 8'hFF, 8'h05, 8'h03, 8'h06);   // undefined command (R9)
    directed(3, 2, 8'h05, 8'h00, 8'h00, 8'h00);   // recovery after lock (R9)

    // R10: partial byte dropped at deselect
    txBuf[0] = 8'h06;
    runTxn(0, 1, 5);
    chk("R10 partial byte no strobe", strobeCnt, 0);
    chk("R10 partial byte no pulse", rxCnt + reqCnt + addrCnt, 0);
    directed(0, 1, 8'h06, 8'h00, 8'h00, 8'h00);

    for (int t = 0; t < 40; t++) begin
      int n;
      int mode;
      mode = ($urandom % 2) ? 3 : 0;
      n = 1 + ($urandom % 7);
      if ($urandom % 4 != 0)
        txBuf[0] = validOps[$urandom % 9] | (($urandom % 2) ? 8'h08 : 8'h00);
      else
        txBuf[0] = 8'($urandom);
      for (int i = 1; i < 16; i++) txBuf[i] = 8'($urandom);
      runTxn(mode, n, 8);
      verifyTxn(n);
    end
    finishRun();
  end
endmodule